// File: doc/BRIEF.md
# Gated Period Timer with Compare Reset

This block is an up-counter whose counting can be qualified by an external gate line. A compare register sits beside it. The counter takes at most one step per cycle, on a single-cycle count strobe that comes from the system clock domain. A control bit selects whether the gate is used, and a polarity bit selects which gate level lets the counter step.

When the compare channel is set to its period mode, the compare register sets the counter's period. After an increment, if the new value equals the compare value, the counter is loaded with zero instead. This clear produces a one-cycle conversion-start pulse when the converter-enable input is high. A natural wrap past the all-ones value sets a sticky overflow flag. The period clear never sets that flag.

Software uses a small write port. It can load the counter, load the compare value, program the control bits, and clear the flag. A counter load always wins over a clear or an increment in the same cycle.

Top module: `gated_period_timer`

## Requirements
- R1: While `rst_n` is low, and for two cycles after it rises, the counter, compare value, control bits, overflow flag and trigger all read zero.
- R2: With control bit 6 (run) clear, the counter ignores strobes and the gate. No trigger pulse occurs and the overflow flag is not set.
- R3: With run set and control bit 5 (gate enable) clear, the counter advances by one in every cycle in which `cnt_stb` is high.
- R4: With run set, gate enable set and control bit 4 (polarity) clear, a strobe advances the counter only while `gate_in` is low. While `gate_in` is high the count holds.
- R5: With run set, gate enable set and polarity set, a strobe advances the counter only while `gate_in` is high. While `gate_in` is low the count holds.
- R6: Write address 2'd1 loads the compare register, and address 2'd2 loads the control bits from `wr_data[6:0]`. When control bits [3:0] equal 4'b1011 (period mode) and an advance would produce a value equal to the compare register, the counter becomes zero instead.
- R7: `conv_trig` is high for exactly the one cycle after the clock edge that performed a period-mode clear, and only if `conv_en` was high in that clock cycle. It is never high in any other mode.
- R8: `ovf_flag` is set when an advance takes the counter from all ones to zero. A period-mode clear from any other value does not set it.
- R9: `ovf_flag` stays set until a write to address 2'd3 with `wr_data[0]` = 1. If a wrap happens in the same cycle as that clearing write, the flag stays set.
- R10: A write to address 2'd0 loads `wr_data` into the counter. This load takes precedence over an increment and over a period-mode clear in the same cycle. The trigger for that clear still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_stb | input | 1 | Single-cycle count strobe |
| gate_in | input | 1 | External gate line |
| conv_en | input | 1 | Converter enable; qualifies the trigger pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 counter, 1 compare, 2 control, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| cmp_o | output | CNT_W | Compare register value |
| ctrl_o | output | 7 | Control bits: run[6], gate enable[5], polarity[4], mode[3:0] |
| ovf_flag | output | 1 | Sticky overflow flag |
| conv_trig | output | 1 | One-cycle conversion start pulse |

## Verification
Three pairs of events can land in the same cycle, and the bench drives each pair on the same edge.

- **Counter load and period clear.** The counter is placed one below the compare value. In period mode, a strobe and a counter write are then issued together. The check confirms that the written value appears and that the trigger pulse still follows.
- **Natural wrap and flag clear.** A wrap is provoked in the same cycle as a flag-clear write, and the flag must remain set.
- **Period clear with no wrap.** A period clear is run from a value that is not all ones, and the flag must stay low.

Expected values come from an arithmetic model in the bench that follows the requirements.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned CTRL_W = 7;
  localparam logic [MODE_W-1:0] MODE_PERIOD = 4'b1011;

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_CMP   = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_FLAG  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              run;
    logic              gate_en;
    logic              gate_pol;
    logic [MODE_W-1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/gpt_gate_qual.sv
module gpt_gate_qual (
  input  logic run,
  input  logic gate_en,
  input  logic gate_pol,
  input  logic gate_in,
  input  logic cnt_stb,
  output logic advance
);
  logic gate_ok;

  always_comb begin
    gate_ok = !gate_en || (gate_in == gate_pol);
    advance = run && cnt_stb && gate_ok;
  end
endmodule

// File: rtl/gpt_ctrl_regs.sv
module gpt_ctrl_regs
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] cmp_q
);
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] cmp_d;
  logic             ctrl_we;
  logic             cmp_we;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
    cmp_we  = wr_en && (wr_addr == ADDR_CMP);
    ctrl_d  = ctrl_t'(wr_data[CTRL_W-1:0]);
    cmp_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (cmp_we)  cmp_q  <= cmp_d;
    end
  end
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             advance,
  input  logic             period_mode,
  input  logic             conv_en,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_count,
  input  logic             wr_flag_clr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             trig_q
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] count_d;
  logic             match;
  logic             wrap;
  logic             ovf_d;
  logic             trig_d;

  always_comb begin
    inc   = count_q + CNT_W'(1);
    match = advance && period_mode && (inc == cmp);
    wrap  = advance && (count_q == ALL_ONES);

    if (wr_count)   count_d = wr_data;
    else if (match) count_d = '0;
    else if (advance) count_d = inc;
    else            count_d = count_q;

    if (wrap)             ovf_d = 1'b1;
    else if (wr_flag_clr) ovf_d = 1'b0;
    else                  ovf_d = ovf_q;

    trig_d = match && conv_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
      trig_q  <= trig_d;
    end
  end

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count) |=> (count_q == $past(count_q)) && !trig_q);

  p_trig_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> $past(conv_en) && $past(period_mode) && $past(run));

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(count_q) == ALL_ONES) && $past(run));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !wr_flag_clr) |=> ovf_q);

  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count_q == $past(wr_data)));
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_stb,
  input  logic               gate_in,
  input  logic               conv_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               ovf_flag,
  output logic               conv_trig
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  ctrl_t      ctrl;
  logic       advance;
  logic       period_mode;
  logic       wr_count;
  logic       wr_flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    period_mode = (ctrl.mode == MODE_PERIOD);
    wr_count    = wr_en && (wr_addr == ADDR_COUNT);
    wr_flag_clr = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
    ctrl_o      = ctrl;
  end

  gpt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl),
    .cmp_q   (cmp_o)
  );

  gpt_gate_qual u_gate (
    .run      (ctrl.run),
    .gate_en  (ctrl.gate_en),
    .gate_pol (ctrl.gate_pol),
    .gate_in  (gate_in),
    .cnt_stb  (cnt_stb),
    .advance  (advance)
  );

  gpt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .run         (ctrl.run),
    .advance     (advance),
    .period_mode (period_mode),
    .conv_en     (conv_en),
    .cmp         (cmp_o),
    .wr_count    (wr_count),
    .wr_flag_clr (wr_flag_clr),
    .wr_data     (wr_data),
    .count_q     (count_o),
    .ovf_q       (ovf_flag),
    .trig_q      (conv_trig)
  );

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl.gate_en && (gate_in != ctrl.gate_pol) && !wr_count)
      |=> (count_o == $past(count_o)));
endmodule

// File: tb/gated_period_timer_bench.sv
module gated_period_timer_bench;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnt_stb, gate_in, conv_en, wr_en;
  logic [1:0]    wr_addr;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  count_o, cmp_o;
  logic [6:0]    ctrl_o;
  logic          ovf_flag, conv_trig;

  logic [W-1:0]  m_cnt, m_cmp;
  logic [6:0]    m_ctrl;
  logic          m_ovf, m_trig;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  always #5 clk = ~clk;

  gated_period_timer #(.CNT_W(W)) u_gated_period_timer (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .gate_in(gate_in),
    .conv_en(conv_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .cmp_o(cmp_o), .ctrl_o(ctrl_o),
    .ovf_flag(ovf_flag), .conv_trig(conv_trig)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic stb, input logic g, input logic adc, input logic wr,
                      input logic [1:0] addr, input logic [W-1:0] data, input string req);
    logic         ok, adv, match;
    logic [W-1:0] inc, n_cnt;
    logic         n_ovf;
    @(negedge clk);
    cnt_stb = stb; gate_in = g; conv_en = adc; wr_en = wr; wr_addr = addr; wr_data = data;
    ok    = !m_ctrl[5] || (g == m_ctrl[4]);
    adv   = m_ctrl[6] && stb && ok;
    inc   = m_cnt + 1'b1;
    match = adv && (m_ctrl[3:0] == 4'b1011) && (inc == m_cmp);
    if (wr && addr == 2'd0) n_cnt = data;
    else if (match)         n_cnt = '0;
    else if (adv)           n_cnt = inc;
    else                    n_cnt = m_cnt;
    if (adv && m_cnt == '1)                 n_ovf = 1'b1;
    else if (wr && addr == 2'd3 && data[0]) n_ovf = 1'b0;
    else                                    n_ovf = m_ovf;
    m_trig = match && adc;
    if (wr && addr == 2'd1) m_cmp  = data;
    if (wr && addr == 2'd2) m_ctrl = data[6:0];
    m_cnt = n_cnt; m_ovf = n_ovf;
    @(posedge clk); #1;
    wr_en = 1'b0; cnt_stb = 1'b0;
    chk(req, "count", count_o, m_cnt);
    chk(req, "trig", conv_trig, m_trig);
    chk(req, "ovf", ovf_flag, m_ovf);
    chk(req, "cmp", cmp_o, m_cmp);
    chk(req, "ctrl", ctrl_o, m_ctrl);
  endtask

  task automatic wr(input logic [1:0] addr, input logic [W-1:0] data, input string req);
    step(1'b0, 1'b0, 1'b0, 1'b1, addr, data, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_stb = 0; gate_in = 0; conv_en = 0; wr_en = 0; wr_addr = 0; wr_data = '0;
    m_cnt = '0; m_cmp = '0; m_ctrl = '0; m_ovf = 0; m_trig = 0;
    repeat (3) @(negedge clk);
    chk("R1", "count", count_o, 0);
    chk("R1", "cmp", cmp_o, 0);
    chk("R1", "ctrl", ctrl_o, 0);
    chk("R1", "ovf", ovf_flag, 0);
    chk("R1", "trig", conv_trig, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "count after release", count_o, 0);

    // Gate sweep: run x gate enable x polarity x gate level x strobe
    for (int run = 0; run < 2; run++)
      for (int ge = 0; ge < 2; ge++)
        for (int pol = 0; pol < 2; pol++) begin
          string tag;
          tag = (run == 0) ? "R2" : (ge == 0) ? "R3" : (pol == 1) ? "R5" : "R4";
          wr(2'd2, W'({run[0], ge[0], pol[0], 4'b0000}), tag);
          for (int g = 0; g < 2; g++)
            for (int s = 0; s < 2; s++)
              step(s[0], g[0], 1'b1, 1'b0, 2'd0, '0, tag);
        end

    // Period mode with gaps in the strobe and conv_en toggling
    wr(2'd1, W'(5), "R6");
    wr(2'd0, W'(0), "R6");
    wr(2'd2, W'(7'b1001011), "R6");
    for (int i = 0; i < 16; i++)
      step((i % 3) != 2, 1'b0, i < 9, 1'b0, 2'd0, '0, "R6 R7");

    // Non-period mode passes the compare value without clearing
    wr(2'd2, W'(7'b1001010), "R7");
    wr(2'd0, W'(2), "R7");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R7");

    // Natural wrap sets the flag
    wr(2'd2, W'(7'b1000000), "R8");
    wr(2'd0, W'(16'hFFFE), "R8");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R8");

    // Sticky flag: a non-clearing write, then a clearing write
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, W'(2), "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R9");
    wr(2'd3, W'(1), "R9");

    // A period clear from a non-all-ones value leaves the flag low
    wr(2'd1, W'(3), "R8");
    wr(2'd0, W'(0), "R8");
    wr(2'd2, W'(7'b1001011), "R8");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R8");

    // A wrap in the same cycle as a clearing write keeps the flag set
    wr(2'd2, W'(7'b1000000), "R9");
    wr(2'd0, W'(16'hFFFF), "R9");
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd3, W'(1), "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R9");

    // A counter write and a period clear in the same cycle
    wr(2'd1, W'(10), "R10");
    wr(2'd2, W'(7'b1001011), "R10");
    wr(2'd0, W'(9), "R10");
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, W'(16'h1234), "R10");
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, W'(16'h00AA), "R10");
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule